// File: doc/BRIEF.md
# PIPE PHY Power State Controller

This block sits on the PHY side of a PIPE-style link and owns the transmitter's power state. The MAC drives a 2-bit power-down request. When the request differs from the state in force, the controller accepts it and waits a fixed number of clocks, set by a parameter. It then applies the new state and raises a one-cycle PHY-done pulse. Each state decides what the transmitter may do. Full operation allows normal data, electrical idle and loopback. The light standby state allows only electrical idle. The deeper standby state powers the buffer down and is the only state that accepts a receiver-detect request. The deepest state sends either electrical idle or a wake-up beacon.

The detection circuit is outside this block. The controller raises a request and waits for a response strobe that carries a present flag. When the strobe arrives, the controller ends detection with a done pulse and reports the result on the 3-bit receiver status bus. Outside that cycle, the bus carries a registered copy of an external error code, or zero. When the MAC sends the compliance pattern during full operation, the controller asserts a flag that forces the encoder's running disparity.

Top module: `pipe_pwr_ctrl`

## Requirements
- R1: After reset, the applied state is deeper standby (encoding 2'b10), and phy_done_o, det_req_o and rx_status_o are all 0.
- R2: State encodings are 2'b00 full operation, 2'b01 light standby, 2'b10 deeper standby and 2'b11 deepest. When the controller is idle and powerdown_i differs from pwr_state_o at a rising edge, that edge accepts the request. pwr_state_o takes the new value, and phy_done_o is high for exactly one cycle, DONE_LAT edges after the accepting edge. pwr_state_o never changes without phy_done_o.
- R3: A power-down change that arrives while a transition or a detection is pending is ignored until the edge that raises that pending operation's done pulse. It is accepted at the edge after that one.
- R4: tx_idle_o is 1 whenever the applied state is not full operation, except while a beacon is being sent. It is also 1 from the edge that accepts a move out of full operation. In stable full operation it follows tx_elecidle_i.
- R5: loopback_o equals loopback_i only in stable full operation. It is 0 at all other times.
- R6: tx_detect_i is accepted only in stable deeper standby with no other operation pending. det_req_o is then 1 from the next edge until the response is taken. A request made in any other state is ignored: it produces no det_req_o and no done pulse.
- R7: det_resp_valid_i, seen at an edge while detection is pending, ends the detection. At that edge phy_done_o pulses and det_req_o drops. In the same cycle, rx_status_o shows 3'b011 if det_resp_present_i is 1, or 3'b000 if it is 0. This result takes precedence over any error code.
- R8: beacon_o equals tx_beacon_i only in stable deepest state. In that state tx_idle_o is the inverse of beacon_o.
- R9: force_disp_o is 1 only when tx_compliance_i is high in stable full operation with tx_elecidle_i low.
- R10: Outside a detection-result cycle, rx_status_o shows rx_err_code_i one edge after rx_err_valid_i is sampled high, and 3'b000 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| powerdown_i | input | 2 | Requested power state from MAC |
| tx_elecidle_i | input | 1 | MAC electrical-idle request |
| loopback_i | input | 1 | MAC loopback request |
| tx_compliance_i | input | 1 | Compliance pattern being sent |
| tx_beacon_i | input | 1 | Beacon request |
| tx_detect_i | input | 1 | Receiver-detect request |
| det_resp_valid_i | input | 1 | Detection circuit response strobe |
| det_resp_present_i | input | 1 | Receiver found, qualified by strobe |
| rx_err_valid_i | input | 1 | Receiver error code valid |
| rx_err_code_i | input | 3 | Receiver error code |
| pwr_state_o | output | 2 | Applied power state |
| tx_idle_o | output | 1 | Transmitter electrical idle |
| loopback_o | output | 1 | Loopback enable |
| beacon_o | output | 1 | Beacon enable |
| force_disp_o | output | 1 | Force encoder disparity |
| det_req_o | output | 1 | Receiver detection in progress |
| phy_done_o | output | 1 | One-cycle completion pulse |
| rx_status_o | output | 3 | Receiver status |

## Verification
Each result has a fixed due time, and the bench samples it at that time. A transition's done pulse and new state appear DONE_LAT edges after the accepting edge. A detection result appears one edge after the response strobe. An error code appears one edge after it is sampled. The transmitter controls are combinational and follow the stable state at once. The bench drives all inputs on falling edges and counts falling edges from the stimulus. It expects each result at exactly one of those falling edges and expects the output to stay quiet at every earlier one. The bench sweeps every pair of source and target states, every state against every combination of transmit controls, and every error code.

// File: rtl/pipe_pwr_pkg.sv
package pipe_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_ON    = 2'b00,
    PWR_LIGHT = 2'b01,
    PWR_DEEP  = 2'b10,
    PWR_OFF   = 2'b11
  } pwr_e;

  localparam logic [2:0] ST_NONE     = 3'b000;
  localparam logic [2:0] ST_RX_FOUND = 3'b011;
endpackage

// File: rtl/pipe_pwr_seq.sv
module pipe_pwr_seq
  import pipe_pwr_pkg::*;
#(
  parameter int unsigned DONE_LAT = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] powerdown_i,
  input  logic       det_busy_i,
  output pwr_e       cur_o,
  output pwr_e       tgt_o,
  output logic       busy_o,
  output logic       start_o,
  output logic       done_o
);
  localparam int unsigned CW = (DONE_LAT > 1) ? $clog2(DONE_LAT) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DONE_LAT - 1);

  pwr_e          cur_q, tgt_q;
  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  pwr_e          req;

  assign req     = pwr_e'(powerdown_i);
  assign start_o = !busy_q && !det_busy_i && (req != cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= PWR_DEEP;
      tgt_q  <= PWR_DEEP;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        tgt_q  <= req;
        busy_q <= 1'b1;
        cnt_q  <= LOAD;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          cur_q  <= tgt_q;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cur_o  = cur_q;
  assign tgt_o  = tgt_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/pipe_rxdet.sv
module pipe_rxdet
  import pipe_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_e       cur_i,
  input  logic       pwr_busy_i,
  input  logic       pwr_start_i,
  input  logic       tx_detect_i,
  input  logic       resp_valid_i,
  input  logic       resp_present_i,
  input  logic       err_valid_i,
  input  logic [2:0] err_code_i,
  output logic       det_busy_o,
  output logic       det_done_o,
  output logic [2:0] status_o
);
  logic       busy_q, done_q;
  logic [2:0] status_q;
  logic       accept, finish;

  // power change wins over a simultaneous detect request
  assign accept = (cur_i == PWR_DEEP) && !pwr_busy_i && !pwr_start_i
                  && !busy_q && tx_detect_i;
  assign finish = busy_q && resp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= ST_NONE;
    end else begin
      done_q <= finish;
      if (accept)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      if (finish)           status_q <= resp_present_i ? ST_RX_FOUND : ST_NONE;
      else if (err_valid_i) status_q <= err_code_i;
      else                  status_q <= ST_NONE;
    end
  end

  assign det_busy_o = busy_q;
  assign det_done_o = done_q;
  assign status_o   = status_q;
endmodule

// File: rtl/pipe_tx_ctl.sv
module pipe_tx_ctl
  import pipe_pwr_pkg::*;
(
  input  pwr_e cur_i,
  input  pwr_e tgt_i,
  input  logic busy_i,
  input  logic elecidle_i,
  input  logic loopback_i,
  input  logic compliance_i,
  input  logic beacon_i,
  output logic tx_idle_o,
  output logic loopback_o,
  output logic beacon_o,
  output logic force_disp_o
);
  logic stable_on, leaving_on;

  assign stable_on  = (cur_i == PWR_ON) && !busy_i;
  assign leaving_on = (cur_i == PWR_ON) && busy_i && (tgt_i != PWR_ON);

  always_comb begin
    beacon_o     = (cur_i == PWR_OFF) && !busy_i && beacon_i;
    loopback_o   = stable_on && loopback_i;
    force_disp_o = stable_on && compliance_i && !elecidle_i;
    unique case (cur_i)
      PWR_ON:  tx_idle_o = leaving_on || elecidle_i;
      PWR_OFF: tx_idle_o = !beacon_o;
      default: tx_idle_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pipe_pwr_ctrl.sv
module pipe_pwr_ctrl
  import pipe_pwr_pkg::*;
#(
  parameter int unsigned DONE_LAT = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] powerdown_i,
  input  logic       tx_elecidle_i,
  input  logic       loopback_i,
  input  logic       tx_compliance_i,
  input  logic       tx_beacon_i,
  input  logic       tx_detect_i,
  input  logic       det_resp_valid_i,
  input  logic       det_resp_present_i,
  input  logic       rx_err_valid_i,
  input  logic [2:0] rx_err_code_i,
  output logic [1:0] pwr_state_o,
  output logic       tx_idle_o,
  output logic       loopback_o,
  output logic       beacon_o,
  output logic       force_disp_o,
  output logic       det_req_o,
  output logic       phy_done_o,
  output logic [2:0] rx_status_o
);
  pwr_e cur, tgt;
  logic pwr_busy, pwr_start, pwr_done;
  logic det_busy, det_done;

  pipe_pwr_seq #(.DONE_LAT(DONE_LAT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .powerdown_i (powerdown_i),
    .det_busy_i  (det_busy),
    .cur_o       (cur),
    .tgt_o       (tgt),
    .busy_o      (pwr_busy),
    .start_o     (pwr_start),
    .done_o      (pwr_done)
  );

  pipe_rxdet u_det (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cur_i          (cur),
    .pwr_busy_i     (pwr_busy),
    .pwr_start_i    (pwr_start),
    .tx_detect_i    (tx_detect_i),
    .resp_valid_i   (det_resp_valid_i),
    .resp_present_i (det_resp_present_i),
    .err_valid_i    (rx_err_valid_i),
    .err_code_i     (rx_err_code_i),
    .det_busy_o     (det_busy),
    .det_done_o     (det_done),
    .status_o       (rx_status_o)
  );

  pipe_tx_ctl u_tx (
    .cur_i        (cur),
    .tgt_i        (tgt),
    .busy_i       (pwr_busy),
    .elecidle_i   (tx_elecidle_i),
    .loopback_i   (loopback_i),
    .compliance_i (tx_compliance_i),
    .beacon_i     (tx_beacon_i),
    .tx_idle_o    (tx_idle_o),
    .loopback_o   (loopback_o),
    .beacon_o     (beacon_o),
    .force_disp_o (force_disp_o)
  );

  assign pwr_state_o = cur;
  assign det_req_o   = det_busy;
  assign phy_done_o  = pwr_done | det_done;
endmodule

// File: rtl/pipe_pwr_ctrl_chk.sv
module pipe_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_detect_i,
  input logic [1:0] pwr_state_o,
  input logic       tx_idle_o,
  input logic       loopback_o,
  input logic       beacon_o,
  input logic       force_disp_o,
  input logic       det_req_o,
  input logic       phy_done_o
);
  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_done_o |=> !phy_done_o);
  assert_state_with_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwr_state_o) |-> phy_done_o);
  assert_idle_low_power_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o != 2'b00) |-> (tx_idle_o || beacon_o));
  assert_loopback_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_o |-> (pwr_state_o == 2'b00));
  assert_detect_deep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_req_o |-> (pwr_state_o == 2'b10));
  assert_detect_requested_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_req_o) |-> $past(tx_detect_i));
  assert_beacon_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beacon_o |-> (pwr_state_o == 2'b11 && !tx_idle_o));
  assert_disp_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_disp_o |-> (pwr_state_o == 2'b00 && !tx_idle_o));
endmodule

bind pipe_pwr_ctrl pipe_pwr_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_detect_i  (tx_detect_i),
  .pwr_state_o  (pwr_state_o),
  .tx_idle_o    (tx_idle_o),
  .loopback_o   (loopback_o),
  .beacon_o     (beacon_o),
  .force_disp_o (force_disp_o),
  .det_req_o    (det_req_o),
  .phy_done_o   (phy_done_o)
);

// File: tb/pipe_pwr_ctrl_tb.sv
module pipe_pwr_ctrl_tb;
  localparam int unsigned LAT = 3;
  localparam time TCLK = 10ns;
  localparam int unsigned WDOG = 100000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pd = 2'b10;
  logic       eidle = 0, lpb = 0, comp = 0, bcn = 0, det = 0;
  logic       rv = 0, rp = 0, ev = 0;
  logic [2:0] ec = 3'd0;
  logic [1:0] st;
  logic       idle, lpo, bco, fdo, dro, done;
  logic [2:0] rxs;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  pipe_pwr_ctrl #(.DONE_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .powerdown_i(pd),
    .tx_elecidle_i(eidle), .loopback_i(lpb), .tx_compliance_i(comp),
    .tx_beacon_i(bcn), .tx_detect_i(det),
    .det_resp_valid_i(rv), .det_resp_present_i(rp),
    .rx_err_valid_i(ev), .rx_err_code_i(ec),
    .pwr_state_o(st), .tx_idle_o(idle), .loopback_o(lpo), .beacon_o(bco),
    .force_disp_o(fdo), .det_req_o(dro), .phy_done_o(done), .rx_status_o(rxs)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_to(logic [1:0] s);
    @(negedge clk) pd = s;
    if (st != s) repeat (LAT + 1) @(negedge clk);
    chk("R2 settle", st, s);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 state", st, 2'b10);
    chk("R1 done", done, 0);
    chk("R1 det_req", dro, 0);
    chk("R1 status", rxs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post state", st, 2'b10);

    // R2/R4: every source/target pair
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        go_to(2'(f));
        pd = 2'(t);
        for (int i = 1; i <= LAT + 1; i++) begin
          logic [1:0] se;
          @(negedge clk);
          se = (i == LAT + 1 && t != f) ? 2'(t) : 2'(f);
          chk("R2 done", done, (t != f) && (i == LAT + 1));
          chk("R2 state", st, se);
          chk("R4 idle", idle, (se != 0) || (f == 0 && t != 0));
        end
        @(negedge clk);
        chk("R2 done once", done, 0);
      end
    end

    // R3: change during pending transition
    go_to(2'b00);
    @(negedge clk) pd = 2'b10;
    @(negedge clk) pd = 2'b11;
    for (int i = 2; i <= LAT + 1; i++) begin
      @(negedge clk);
      chk("R3 first done", done, i == LAT + 1);
    end
    chk("R3 first target", st, 2'b10);
    for (int j = 1; j <= LAT + 1; j++) begin
      @(negedge clk);
      chk("R3 second done", done, j == LAT + 1);
      chk("R3 second state", st, (j == LAT + 1) ? 2'b11 : 2'b10);
    end

    // R6: detect request in each state
    for (int s = 0; s < 4; s++) begin
      go_to(2'(s));
      @(negedge clk) det = 1;
      @(negedge clk) det = 0;
      chk("R6 det_req", dro, s == 2);
      if (s != 2) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk("R6 ignored done", done, 0);
          chk("R6 ignored req", dro, 0);
        end
      end else begin
        @(negedge clk) rv = 1; rp = 0;
        @(negedge clk) rv = 0;
        chk("R7 done", done, 1);
        chk("R7 status none", rxs, 3'b000);
      end
    end

    // R7: result with varying wait, error code collides in result cycle
    for (int d = 0; d < 3; d++) begin
      for (int p = 0; p < 2; p++) begin
        go_to(2'b10);
        @(negedge clk) det = 1;
        @(negedge clk) det = 0;
        for (int k = 0; k < d; k++) begin
          chk("R7 waiting req", dro, 1);
          chk("R7 waiting done", done, 0);
          @(negedge clk);
        end
        rv = 1; rp = p[0]; ev = 1; ec = 3'b111;
        @(negedge clk) rv = 0; ev = 0;
        chk("R7 done", done, 1);
        chk("R7 req drop", dro, 0);
        chk("R7 status", rxs, p ? 3'b011 : 3'b000);
        @(negedge clk);
        chk("R7 single", done, 0);
        chk("R10 idle status", rxs, 0);
      end
    end

    // R3: power change held off by a pending detection
    go_to(2'b10);
    @(negedge clk) det = 1;
    @(negedge clk) det = 0; pd = 2'b00;
    repeat (3) begin
      @(negedge clk);
      chk("R3 held by detect", st, 2'b10);
      chk("R3 held done", done, 0);
    end
    rv = 1; rp = 1;
    @(negedge clk) rv = 0;
    chk("R3 detect done", done, 1);
    for (int i = 1; i <= LAT + 1; i++) begin
      @(negedge clk);
      chk("R3 after detect", done, i == LAT + 1);
    end
    chk("R3 after detect state", st, 2'b00);

    // R4/R5/R8/R9: every stable state against all transmit controls
    for (int s = 0; s < 4; s++) begin
      go_to(2'(s));
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        {eidle, lpb, comp, bcn} = 4'(v);
        #1;
        chk("R4 idle", idle, s == 0 ? eidle : (s == 3 ? !bcn : 1'b1));
        chk("R5 loopback", lpo, s == 0 && lpb);
        chk("R8 beacon", bco, s == 3 && bcn);
        chk("R9 disparity", fdo, s == 0 && comp && !eidle);
      end
      @(negedge clk) {eidle, lpb, comp, bcn} = 4'b0;
    end

    // R10: every error code
    for (int c = 0; c < 8; c++) begin
      @(negedge clk) ev = 1; ec = 3'(c);
      @(negedge clk) ev = 0;
      chk("R10 code", rxs, c);
      @(negedge clk);
      chk("R10 clear", rxs, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule